// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block decides, every clock cycle, whether a pending interrupt deserves a trap. Requests come from two vectors sharing one bit space: software requests sit in a low window of positions and external lines in a higher window. Both are converted to levels in a single level space. A software request at position i takes level i − SW_LO + 1. An external request at position i takes level i. The external window lies above the software window, so every external level outranks every software level.

The winning level is compared with a 5-bit current priority register. A trap is raised only when the winning level is strictly above that register. When a trap is raised, the block captures two values on the same edge: a summary vector with one bit per pending source, and the winning level as an interrupt ID. The block then waits for an acknowledge before it evaluates requests again. A nonzero asynchronous-trap request is not serviced; it sets a sticky error flag instead.

A two-state machine controls the sequencing:
- `ARB_SCAN`: the block evaluates the requests every cycle.
- `ARB_HOLD`: a trap has been issued and further traps are held off.
- Transition `fire` (`ARB_SCAN` to `ARB_HOLD`): taken when the winning level exceeds the current level. It pulses `trap_o` and captures the summary and the ID.
- Transition `ack` (`ARB_HOLD` to `ARB_SCAN`): taken on `trap_ack`.

Top module: `irq_level_arb`

## Requirements
- R1: A software request at bit i, with 4 ≤ i ≤ 18, maps to level i − 3.
- R2: An external request at bit i, with 20 ≤ i ≤ 30, maps to level i. Any pending external request beats every software request.
- R3: Within a class, the highest-numbered pending bit sets the level.
- R4: The summary has bit i set exactly for each pending in-window source i. Request bits outside both windows cause no trap and never appear in the summary.
- R5: A trap is raised only when the level is nonzero and strictly greater than the current level. An equal level raises no trap.
- R6: `summary_o` and `intid_o` update on the same edge that raises `trap_o`, and hold their values at all other times.
- R7: A write through `ipl_wr_en` keeps the low 5 bits of `ipl_wr_data`. A trap decision made in the cycle of a write compares against the level held before that write.
- R8: `trap_o` lasts exactly one cycle. No further trap is raised until `trap_ack` is seen in `ARB_HOLD`. `trap_ack` in `ARB_SCAN` has no effect.
- R9: Any nonzero `ast_req` sets `ast_err_o`, which stays set until reset. `ast_req` never raises a trap.
- R10: Reset clears `trap_o`, `summary_o`, `intid_o`, `cur_ipl_o` and `ast_err_o`, and puts the machine in `ARB_SCAN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | 32 | Software request vector (window 4..18) |
| ext_req | input | 32 | External request vector (window 20..30) |
| ipl_wr_en | input | 1 | Write strobe for the current level |
| ipl_wr_data | input | 8 | Write data; low 5 bits are kept |
| ast_req | input | 4 | Asynchronous-trap request (error if nonzero) |
| trap_ack | input | 1 | Acknowledge of an issued trap |
| trap_o | output | 1 | One-cycle trap strobe |
| summary_o | output | 32 | Captured pending-source summary |
| intid_o | output | 5 | Captured winning level |
| cur_ipl_o | output | 5 | Current priority level |
| ast_err_o | output | 1 | Sticky asynchronous-trap error |

## Verification
Two functions can land on the same clock edge: a write to the current level and a trap decision. The bench sets the level to 7, then in one cycle writes 0x1F while a software request of level 8 is pending. It expects the trap to fire, because the decision uses the old level 7, and it expects the readback level to be 31 afterwards. A second overlap pairs an acknowledge with a request that is still pending. The bench expects no strobe in the cycle of the acknowledge and a fresh strobe one cycle later.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    typedef enum logic [0:0] {
        ARB_SCAN = 1'b0,
        ARB_HOLD = 1'b1
    } arb_state_e;
endpackage

// File: rtl/irq_lvl_enc.sv
// Priority encoder over one window of a request vector.
// The level of bit i is i - LO + BIAS; the highest set bit wins.
module irq_lvl_enc #(
    parameter int VEC_W = 32,
    parameter int LO    = 4,
    parameter int HI    = 18,
    parameter int LVL_W = 5,
    parameter int BIAS  = 1
) (
    input  logic [VEC_W-1:0] req,
    output logic [VEC_W-1:0] mask,
    output logic [LVL_W-1:0] level,
    output logic             any
);
    function automatic logic [VEC_W-1:0] win_f();
        logic [VEC_W-1:0] w;
        w = '0;
        for (int b = LO; b <= HI; b++) w[b] = 1'b1;
        return w;
    endfunction

    localparam logic [VEC_W-1:0] WIN = win_f();

    assign mask = req & WIN;
    assign any  = |mask;

    always_comb begin
        level = '0;
        for (int i = LO; i <= HI; i++) begin
            if (req[i]) level = LVL_W'(i - LO + BIAS);
        end
    end
endmodule

// File: rtl/irq_ipl_reg.sv
// Current priority level register; keeps only the low LVL_W bits of a write.
module irq_ipl_reg #(
    parameter int IN_W  = 8,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IN_W-1:0]  wr_data,
    output logic [LVL_W-1:0] ipl
);
    always_ff @(posedge clk) begin
        if (!rst_n)     ipl <= '0;
        else if (wr_en) ipl <= LVL_W'(wr_data);
    end
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
    import irq_arb_pkg::*;
#(
    parameter int VEC_W    = 32,
    parameter int SW_LO    = 4,
    parameter int SW_HI    = 18,
    parameter int EXT_LO   = 20,
    parameter int EXT_HI   = 30,
    parameter int LVL_W    = 5,
    parameter int IPL_IN_W = 8,
    parameter int AST_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [VEC_W-1:0]    sw_req,
    input  logic [VEC_W-1:0]    ext_req,
    input  logic                ipl_wr_en,
    input  logic [IPL_IN_W-1:0] ipl_wr_data,
    input  logic [AST_W-1:0]    ast_req,
    input  logic                trap_ack,
    output logic                trap_o,
    output logic [VEC_W-1:0]    summary_o,
    output logic [LVL_W-1:0]    intid_o,
    output logic [LVL_W-1:0]    cur_ipl_o,
    output logic                ast_err_o
);
    localparam int SW_BIAS  = 1;
    localparam int EXT_BIAS = EXT_LO;

    logic [VEC_W-1:0] sw_mask, ext_mask, pend_sum;
    logic [LVL_W-1:0] sw_lvl, ext_lvl, win_lvl;
    logic             sw_any, ext_any, fire;
    arb_state_e       state, state_nx;

    irq_lvl_enc #(.VEC_W(VEC_W), .LO(SW_LO), .HI(SW_HI),
                  .LVL_W(LVL_W), .BIAS(SW_BIAS)) u_sw_enc (
        .req(sw_req), .mask(sw_mask), .level(sw_lvl), .any(sw_any));

    irq_lvl_enc #(.VEC_W(VEC_W), .LO(EXT_LO), .HI(EXT_HI),
                  .LVL_W(LVL_W), .BIAS(EXT_BIAS)) u_ext_enc (
        .req(ext_req), .mask(ext_mask), .level(ext_lvl), .any(ext_any));

    irq_ipl_reg #(.IN_W(IPL_IN_W), .LVL_W(LVL_W)) u_ipl (
        .clk(clk), .rst_n(rst_n), .wr_en(ipl_wr_en),
        .wr_data(ipl_wr_data), .ipl(cur_ipl_o));

    // External window ranks above the software window.
    assign win_lvl  = ext_any ? ext_lvl : sw_lvl;
    assign pend_sum = sw_mask | ext_mask;
    assign fire     = (state == ARB_SCAN) && (sw_any || ext_any) &&
                      (win_lvl != '0) && (win_lvl > cur_ipl_o);

    always_comb begin
        state_nx = state;
        unique case (state)
            ARB_SCAN: if (fire)     state_nx = ARB_HOLD;
            ARB_HOLD: if (trap_ack) state_nx = ARB_SCAN;
            default:                state_nx = ARB_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ARB_SCAN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_o    <= 1'b0;
            summary_o <= '0;
            intid_o   <= '0;
            ast_err_o <= 1'b0;
        end else begin
            trap_o <= fire;
            if (fire) begin
                summary_o <= pend_sum;
                intid_o   <= win_lvl;
            end
            if (|ast_req) ast_err_o <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
    parameter int LVL_W    = 5,
    parameter int IPL_IN_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                trap_o,
    input logic                trap_ack,
    input logic                in_hold,
    input logic [LVL_W-1:0]    intid_o,
    input logic [LVL_W-1:0]    cur_ipl_o,
    input logic                ipl_wr_en,
    input logic [IPL_IN_W-1:0] ipl_wr_data,
    input logic                ast_err_o
);
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> !trap_o);

    p_hold_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hold && !trap_ack) |=> !trap_o);

    p_above_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (intid_o > $past(cur_ipl_o)));

    p_id_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (intid_o != '0));

    p_id_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |-> $stable(intid_o));

    p_level_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ipl_wr_en |=> (cur_ipl_o == LVL_W'($past(ipl_wr_data))));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ast_err_o |=> ast_err_o);
endmodule

bind irq_level_arb irq_arb_chk #(.LVL_W(LVL_W), .IPL_IN_W(IPL_IN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .trap_o(trap_o), .trap_ack(trap_ack),
    .in_hold(state == irq_arb_pkg::ARB_HOLD), .intid_o(intid_o),
    .cur_ipl_o(cur_ipl_o), .ipl_wr_en(ipl_wr_en),
    .ipl_wr_data(ipl_wr_data), .ast_err_o(ast_err_o));

// File: tb/tb_irq_level_arb.sv
`timescale 1ns/1ps
module tb_irq_level_arb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] sw_req, ext_req;
    logic        ipl_wr_en;
    logic [7:0]  ipl_wr_data;
    logic [3:0]  ast_req;
    logic        trap_ack;
    logic        trap_o, ast_err_o;
    logic [31:0] summary_o;
    logic [4:0]  intid_o, cur_ipl_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    irq_level_arb dut (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .ext_req(ext_req),
        .ipl_wr_en(ipl_wr_en), .ipl_wr_data(ipl_wr_data), .ast_req(ast_req),
        .trap_ack(trap_ack), .trap_o(trap_o), .summary_o(summary_o),
        .intid_o(intid_o), .cur_ipl_o(cur_ipl_o), .ast_err_o(ast_err_o));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_ipl(logic [7:0] d);
        ipl_wr_en = 1'b1; ipl_wr_data = d;
        step();
        ipl_wr_en = 1'b0;
    endtask

    task automatic ack();
        sw_req = '0; ext_req = '0;
        trap_ack = 1'b1;
        step();
        trap_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 trap", trap_o, 0);
        chk("R10 summary", summary_o, 0);
        chk("R10 intid", intid_o, 0);
        chk("R10 ipl", cur_ipl_o, 0);
        chk("R10 ast_err", ast_err_o, 0);
    endtask

    task automatic t_sw_levels();
        sw_req = 32'h1 << 4;
        step();
        chk("R1 trap lowest sw", trap_o, 1);
        chk("R1 intid bit4", intid_o, 1);
        chk("R4 summary bit4", summary_o, 32'h10);
        step();
        chk("R8 single pulse", trap_o, 0);
        ack();
        sw_req = 32'h1 << 18;
        step();
        chk("R1 intid bit18", intid_o, 15);
        ack();
    endtask

    task automatic t_priority();
        sw_req = (32'h1 << 5) | (32'h1 << 9) | (32'h1 << 12);
        step();
        chk("R3 sw highest wins", intid_o, 9);
        chk("R4 sw summary", summary_o, 32'h1220);
        ack();
        sw_req = 32'h1 << 18;
        ext_req = (32'h1 << 20) | (32'h1 << 25);
        step();
        chk("R2 ext beats sw", intid_o, 25);
        chk("R4 mixed summary", summary_o, 32'h0214_0000);
        ack();
        ext_req = 32'h1 << 30;
        step();
        chk("R2 ext bit30", intid_o, 30);
        ack();
    endtask

    task automatic t_window();
        sw_req = 32'h1 | (32'h1 << 19) | (32'h1 << 25);
        ext_req = (32'h1 << 19) | (32'h1 << 31) | (32'h1 << 3);
        step();
        chk("R4 out-of-window no trap", trap_o, 0);
        step();
        chk("R4 out-of-window no trap 2", trap_o, 0);
        chk("R4 intid untouched", intid_o, 30);
        sw_req = 32'h1 | (32'h1 << 6);
        step();
        chk("R4 summary excludes window", summary_o, 32'h40);
        ack();
    endtask

    task automatic t_strict();
        set_ipl(8'd9);
        sw_req = 32'h1 << 12;
        step();
        chk("R5 equal level no trap", trap_o, 0);
        sw_req = 32'h1 << 13;
        step();
        chk("R5 above level traps", trap_o, 1);
        chk("R5 intid", intid_o, 10);
        ack();
    endtask

    task automatic t_level_write();
        set_ipl(8'hE7);
        chk("R7 low 5 bits kept", cur_ipl_o, 7);
        ipl_wr_en = 1'b1; ipl_wr_data = 8'h1F;
        sw_req = 32'h1 << 11;
        step();
        ipl_wr_en = 1'b0;
        chk("R7 decision uses old level", trap_o, 1);
        chk("R7 level after write", cur_ipl_o, 31);
        ack();
        ext_req = 32'h1 << 30;
        step();
        chk("R5 top level masks all", trap_o, 0);
        ext_req = '0;
        set_ipl(8'd0);
    endtask

    task automatic t_hold();
        trap_ack = 1'b1;
        step();
        trap_ack = 1'b0;
        sw_req = 32'h1 << 7;
        step();
        chk("R8 ack in scan ignored", trap_o, 1);
        chk("R6 intid on trap", intid_o, 4);
        ext_req = 32'h1 << 28;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R8 no trap in hold", trap_o, 0);
            chk("R6 intid holds", intid_o, 4);
            chk("R6 summary holds", summary_o, 32'h80);
        end
        trap_ack = 1'b1;
        step();
        trap_ack = 1'b0;
        chk("R8 no strobe on ack cycle", trap_o, 0);
        step();
        chk("R8 retrap after ack", trap_o, 1);
        chk("R2 retrap level", intid_o, 28);
        ack();
    endtask

    task automatic t_ast();
        ast_req = 4'b0100;
        step();
        chk("R9 err set", ast_err_o, 1);
        chk("R9 no trap", trap_o, 0);
        ast_req = '0;
        step();
        chk("R9 err sticky", ast_err_o, 1);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sw_req = '0; ext_req = '0; ipl_wr_en = 1'b0;
        ipl_wr_data = '0; ast_req = '0; trap_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sw_levels();
        t_priority();
        t_window();
        t_strict();
        t_level_write();
        t_hold();
        t_ast();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule